// File: doc/BRIEF.md
# Packed Ping-Pong Frame Store

This block captures a raster video stream into one of two single-port memory banks while the other bank serves random reads for downstream processing. Each incoming pixel carries a valid strobe, and optional start-of-frame and end-of-frame flags. Pixels are gathered into 32-bit memory words, either four 8-bit grey pixels or two 16-bit colour pixels, chosen by a parameter. A word goes to the capture bank only once all of its lanes are present. A single memory access therefore moves several pixels.

When an accepted pixel carries the end-of-frame flag, the two banks trade roles. The bank that was just filled becomes readable from the next cycle on, and capture continues into the other bank. The read side takes a pixel coordinate and, one cycle later, returns the whole packed word that holds that pixel, the same word split into lanes, and the addressed pixel. The two banks sit outside the block: it drives their enable, write strobe, address and write data, and receives their read data.

Top module: `pingpong_pack_fb`

## Requirements
- R1: Captured words are written only to the bank that is not readable. At most one bank is written in any cycle.
- R2: After reset, bank 1 is readable (`rd_bank` = 1) and bank 0 takes writes. `rd_bank` inverts in the cycle after an accepted pixel (`in_valid` high) that carries `in_eof`, and is stable otherwise.
- R3: Each bank sees at most one access per cycle. The readable bank is enabled exactly when `rd_req` is high and is never written. The capture bank is enabled only to write.
- R4: With `GRAY_MODE`=1 a word holds four 8-bit pixels. With `GRAY_MODE`=0 it holds two 16-bit pixels. The pixel with the lowest x sits in bits [PIX_W-1:0], and each higher lane holds the next pixel along the row.
- R5: The pixel index is y*FRAME_W+x. A word is written at address index/LANES, combinationally in the cycle that its last lane (index mod LANES = LANES-1) is accepted.
- R6: An accepted pixel with `in_sof` takes index 0. Lanes gathered before it that did not complete a word are never written.
- R7: A read requested with `rd_req`, `rd_x` and `rd_y` in one cycle returns `rd_valid`=1, the packed word `rd_word`, its lanes `rd_lanes` and the pixel `rd_pix` (lane x mod LANES) in the next cycle. `rd_valid` is 0 one cycle after a cycle without a request.
- R8: A read requested in the same cycle as an end-of-frame pixel returns data from the bank that was readable before the swap.
- R9: Pixels whose index is FRAME_W*FRAME_H or more produce no bank write. The next accepted end-of-frame pixel still swaps the banks and restarts the index at 0.
- R10: A cycle with `in_valid` low changes neither the index, nor the captured data, nor `rd_bank`, whatever the values of `in_sof`, `in_eof` and `in_pix`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel strobe of the input stream |
| in_sof | input | 1 | First pixel of a frame |
| in_eof | input | 1 | Last pixel of a frame |
| in_pix | input | PIX_W | Input pixel value |
| rd_req | input | 1 | Read request |
| rd_x | input | X_W | Column of the requested pixel |
| rd_y | input | Y_W | Row of the requested pixel |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_word | output | 32 | Packed word holding the requested pixel |
| rd_lanes | output | LANES x PIX_W | Same word split into pixel lanes |
| rd_pix | output | PIX_W | Requested pixel |
| rd_bank | output | 1 | Index of the bank that is currently readable |
| bank_en | output | 2 | Per-bank access enable |
| bank_we | output | 2 | Per-bank write strobe |
| bank_addr | output | 2 x ADDR_W | Per-bank word address |
| bank_wdata | output | 2 x 32 | Per-bank write word |
| bank_rdata | input | 2 x 32 | Per-bank read word, registered inside the memory one cycle after an enabled read |

## Verification
The assertions take three things for granted. The memories return read data on the clock edge after an enabled read. `rd_x` and `rd_y` stay inside the frame. A frame starts with `in_sof` or directly after an accepted `in_eof`, so lanes fill in index order. The stimulus keeps every coordinate in range and models both banks as one-cycle synchronous memories. It also sends frames of exactly the nominal size, a frame cut short by a new start flag, and an over-long frame. Idle cycles with start and end flags set but `in_valid` low are mixed in, and reads are placed in the end-of-frame cycle, so both the swap timing and the ignore paths are exercised in both packing modes.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

   localparam int unsigned PFB_WORD_W = 32;

   // pixel width for the selected packing mode
   function automatic int unsigned pfb_pix_w(input bit gray);
      return gray ? 8 : 16;
   endfunction

   // lanes carried by one memory word
   function automatic int unsigned pfb_lanes(input bit gray);
      return PFB_WORD_W / pfb_pix_w(gray);
   endfunction

   typedef enum logic {
      PFB_BANK0 = 1'b0,
      PFB_BANK1 = 1'b1
   } pfb_bank_e;

endpackage

// File: rtl/pfb_raster_index.sv
module pfb_raster_index #(
   parameter int unsigned NPIX   = 16,
   parameter int unsigned LANES  = 4,
   parameter int unsigned IDX_W  = 5,
   parameter int unsigned LANE_W = 2,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eof,
   output logic              in_range,
   output logic              last_lane,
   output logic [LANE_W-1:0] lane,
   output logic [ADDR_W-1:0] word_addr
);

   logic [IDX_W-1:0] cnt_q;
   logic [IDX_W-1:0] cur_idx;

   assign cur_idx   = in_sof ? '0 : cnt_q;
   assign in_range  = cur_idx < IDX_W'(NPIX);
   assign lane      = cur_idx[LANE_W-1:0];
   assign last_lane = (lane == LANE_W'(LANES - 1));
   assign word_addr = ADDR_W'(cur_idx >> LANE_W);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (in_valid) begin
         if (in_eof)        cnt_q <= '0;
         else if (in_range) cnt_q <= cur_idx + 1'b1;
         else               cnt_q <= cur_idx;
      end
   end

   // R5: an accepted in-frame pixel moves the index forward by one
   p_idx_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_eof && in_range) |=> (cnt_q == IDX_W'($past(cur_idx) + 1'b1)));

   // R6: end of frame restarts the index
   p_eof_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof) |=> (cnt_q == '0));

   // R10: idle cycles keep the index
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(cnt_q));

   // R9: the index never runs past the frame
   p_idx_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= IDX_W'(NPIX));

endmodule

// File: rtl/pfb_lane_packer.sv
module pfb_lane_packer #(
   parameter int unsigned PIX_W  = 8,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pix_valid,
   input  logic                   in_range,
   input  logic [LANE_W-1:0]      lane,
   input  logic [PIX_W-1:0]       pix,
   output logic [LANES*PIX_W-1:0] word
);

   logic [PIX_W-1:0] hold_q [LANES-1];

   for (genvar k = 0; k < LANES - 1; k++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            hold_q[k] <= '0;
         else if (pix_valid && in_range && (lane == LANE_W'(k)))
            hold_q[k] <= pix;
      end
      assign word[k*PIX_W +: PIX_W] = hold_q[k];

      // R4: the pixel accepted for lane k is the one held there afterwards
      p_lane_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (pix_valid && in_range && (lane == LANE_W'(k))) |=> (hold_q[k] == $past(pix)));
   end

   // the top lane travels straight from the input in the commit cycle
   assign word[(LANES-1)*PIX_W +: PIX_W] = pix;

endmodule

// File: rtl/pfb_bank_switch.sv
module pfb_bank_switch #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned WORD_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         swap,
   input  logic                         wr_commit,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [WORD_W-1:0]            wr_word,
   input  logic                         rd_req,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic                         rd_bank,
   output logic [1:0]                   bank_en,
   output logic [1:0]                   bank_we,
   output logic [1:0][ADDR_W-1:0]       bank_addr,
   output logic [1:0][WORD_W-1:0]       bank_wdata
);
   import pfb_pkg::*;

   pfb_bank_e rd_bank_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    rd_bank_q <= PFB_BANK1;
      else if (swap) rd_bank_q <= (rd_bank_q == PFB_BANK0) ? PFB_BANK1 : PFB_BANK0;
   end

   assign rd_bank = rd_bank_q;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic is_capture;
      assign is_capture = (rd_bank_q != pfb_bank_e'(b));
      always_comb begin
         bank_we[b]    = is_capture & wr_commit;
         bank_en[b]    = is_capture ? wr_commit : rd_req;
         bank_addr[b]  = is_capture ? wr_addr : rd_addr;
         bank_wdata[b] = wr_word;
      end
   end

   // R2: roles exchange in the cycle after end of frame
   p_swap_after_eof_r2: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> (rd_bank_q != $past(rd_bank_q)));

   // R2: no exchange without end of frame
   p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !swap |=> $stable(rd_bank_q));

   // R1: never more than one bank written
   p_one_writer_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_we));

   // R3: a read uses the readable bank and does not write it
   p_read_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (bank_en[rd_bank_q] && !bank_we[rd_bank_q]));

endmodule

// File: rtl/pfb_read_unpack.sv
module pfb_read_unpack #(
   parameter int unsigned PIX_W  = 8,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 2,
   parameter int unsigned WORD_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd_req,
   input  logic [LANE_W-1:0]            rd_lane,
   input  logic                         rd_bank,
   input  logic [1:0][WORD_W-1:0]       bank_rdata,
   output logic                         rd_valid,
   output logic [WORD_W-1:0]            rd_word,
   output logic [LANES-1:0][PIX_W-1:0]  rd_lanes,
   output logic [PIX_W-1:0]             rd_pix
);

   logic              v_q;
   logic              src_q;
   logic [LANE_W-1:0] lane_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         src_q  <= 1'b0;
         lane_q <= '0;
      end else begin
         v_q <= rd_req;
         if (rd_req) begin
            src_q  <= rd_bank;
            lane_q <= rd_lane;
         end
      end
   end

   assign rd_valid = v_q;
   assign rd_word  = bank_rdata[src_q];
   assign rd_lanes = rd_word;
   assign rd_pix   = rd_lanes[lane_q];

   // R7: every request answers exactly one cycle later
   p_rd_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   p_rd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);

endmodule

// File: rtl/pingpong_pack_fb.sv
module pingpong_pack_fb
   import pfb_pkg::*;
#(
   parameter int unsigned FRAME_W   = 768,
   parameter int unsigned FRAME_H   = 576,
   parameter bit          GRAY_MODE = 1'b1,
   localparam int unsigned PIX_W  = pfb_pix_w(GRAY_MODE),
   localparam int unsigned LANES  = pfb_lanes(GRAY_MODE),
   localparam int unsigned LANE_W = $clog2(LANES),
   localparam int unsigned NPIX   = FRAME_W * FRAME_H,
   localparam int unsigned WORDS  = NPIX / LANES,
   localparam int unsigned ADDR_W = $clog2(WORDS),
   localparam int unsigned IDX_W  = $clog2(NPIX + 1),
   localparam int unsigned X_W    = $clog2(FRAME_W),
   localparam int unsigned Y_W    = $clog2(FRAME_H)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic                         in_sof,
   input  logic                         in_eof,
   input  logic [PIX_W-1:0]             in_pix,
   input  logic                         rd_req,
   input  logic [X_W-1:0]               rd_x,
   input  logic [Y_W-1:0]               rd_y,
   output logic                         rd_valid,
   output logic [PFB_WORD_W-1:0]        rd_word,
   output logic [LANES-1:0][PIX_W-1:0]  rd_lanes,
   output logic [PIX_W-1:0]             rd_pix,
   output logic                         rd_bank,
   output logic [1:0]                   bank_en,
   output logic [1:0]                   bank_we,
   output logic [1:0][ADDR_W-1:0]       bank_addr,
   output logic [1:0][PFB_WORD_W-1:0]   bank_wdata,
   input  logic [1:0][PFB_WORD_W-1:0]   bank_rdata
);

   // elaboration-time parameter checks
   if (FRAME_W < 2 || FRAME_H < 2) begin : g_bad_size
      $error("pingpong_pack_fb: frame must be at least 2x2");
   end
   if ((FRAME_W % LANES) != 0) begin : g_bad_width
      $error("pingpong_pack_fb: FRAME_W must be a multiple of the lane count");
   end
   if (PIX_W * LANES != PFB_WORD_W) begin : g_bad_pack
      $error("pingpong_pack_fb: lanes do not fill the memory word");
   end

   logic              in_range;
   logic              last_lane;
   logic [LANE_W-1:0] wr_lane;
   logic [ADDR_W-1:0] wr_addr;
   logic              wr_commit;
   logic              swap;
   logic [PFB_WORD_W-1:0] wr_word;
   logic [IDX_W-1:0]  rd_lin;
   logic [ADDR_W-1:0] rd_addr;
   logic [LANE_W-1:0] rd_lane;

   pfb_raster_index #(
      .NPIX(NPIX), .LANES(LANES), .IDX_W(IDX_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W)
   ) u_index (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
      .in_range(in_range), .last_lane(last_lane), .lane(wr_lane), .word_addr(wr_addr)
   );

   pfb_lane_packer #(
      .PIX_W(PIX_W), .LANES(LANES), .LANE_W(LANE_W)
   ) u_pack (
      .clk(clk), .rst_n(rst_n), .pix_valid(in_valid), .in_range(in_range),
      .lane(wr_lane), .pix(in_pix), .word(wr_word)
   );

   assign wr_commit = in_valid & in_range & last_lane;
   assign swap      = in_valid & in_eof;

   assign rd_lin  = IDX_W'(rd_y) * IDX_W'(FRAME_W) + IDX_W'(rd_x);
   assign rd_addr = ADDR_W'(rd_lin >> LANE_W);
   assign rd_lane = rd_lin[LANE_W-1:0];

   pfb_bank_switch #(
      .ADDR_W(ADDR_W), .WORD_W(PFB_WORD_W)
   ) u_switch (
      .clk(clk), .rst_n(rst_n), .swap(swap), .wr_commit(wr_commit),
      .wr_addr(wr_addr), .wr_word(wr_word), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_bank(rd_bank), .bank_en(bank_en), .bank_we(bank_we),
      .bank_addr(bank_addr), .bank_wdata(bank_wdata)
   );

   pfb_read_unpack #(
      .PIX_W(PIX_W), .LANES(LANES), .LANE_W(LANE_W), .WORD_W(PFB_WORD_W)
   ) u_unpack (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_lane(rd_lane), .rd_bank(rd_bank),
      .bank_rdata(bank_rdata), .rd_valid(rd_valid), .rd_word(rd_word),
      .rd_lanes(rd_lanes), .rd_pix(rd_pix)
   );

   // R5: a commit always lands in the bank that is not readable, at the pixel's word
   p_commit_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> (bank_we[!rd_bank] && (bank_addr[!rd_bank] == wr_addr)));

   // R9: pixels past the frame never reach a bank
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_range) |-> (bank_we == 2'b00));

endmodule

// File: tb/pfb_bank_model.sv
module pfb_bank_model #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DEPTH  = 16
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata
);
   logic [31:0] mem [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;
      rdata = '0;
   end

   always @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end
endmodule

// File: tb/pingpong_pack_fb_test.sv
`timescale 1ns/1ps
module pingpong_pack_fb_test;

   localparam int FW   = 8;
   localparam int FH   = 3;
   localparam int NPIX = FW * FH;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n;
   logic        in_valid, in_sof, in_eof;
   logic [15:0] in_pix;
   logic        rd_req;
   logic [2:0]  rd_x;
   logic [1:0]  rd_y;

   // grey instance: 4 lanes of 8 bits
   logic            g_rd_valid, g_rd_bank;
   logic [31:0]     g_rd_word;
   logic [3:0][7:0] g_rd_lanes;
   logic [7:0]      g_rd_pix;
   logic [1:0]      g_en, g_we;
   logic [1:0][2:0] g_addr;
   logic [1:0][31:0] g_wdata, g_rdata;

   // colour instance: 2 lanes of 16 bits
   logic             r_rd_valid, r_rd_bank;
   logic [31:0]      r_rd_word;
   logic [1:0][15:0] r_rd_lanes;
   logic [15:0]      r_rd_pix;
   logic [1:0]       r_en, r_we;
   logic [1:0][3:0]  r_addr;
   logic [1:0][31:0] r_wdata, r_rdata;

   pingpong_pack_fb #(.FRAME_W(FW), .FRAME_H(FH), .GRAY_MODE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
      .in_pix(in_pix[7:0]), .rd_req(rd_req), .rd_x(rd_x), .rd_y(rd_y),
      .rd_valid(g_rd_valid), .rd_word(g_rd_word), .rd_lanes(g_rd_lanes), .rd_pix(g_rd_pix),
      .rd_bank(g_rd_bank), .bank_en(g_en), .bank_we(g_we), .bank_addr(g_addr),
      .bank_wdata(g_wdata), .bank_rdata(g_rdata)
   );

   pingpong_pack_fb #(.FRAME_W(FW), .FRAME_H(FH), .GRAY_MODE(1'b0)) uut_rgb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
      .in_pix(in_pix), .rd_req(rd_req), .rd_x(rd_x), .rd_y(rd_y),
      .rd_valid(r_rd_valid), .rd_word(r_rd_word), .rd_lanes(r_rd_lanes), .rd_pix(r_rd_pix),
      .rd_bank(r_rd_bank), .bank_en(r_en), .bank_we(r_we), .bank_addr(r_addr),
      .bank_wdata(r_wdata), .bank_rdata(r_rdata)
   );

   for (genvar b = 0; b < 2; b++) begin : g_mem
      pfb_bank_model #(.ADDR_W(3), .DEPTH(8)) u_gmem (
         .clk(clk), .en(g_en[b]), .we(g_we[b]), .addr(g_addr[b]),
         .wdata(g_wdata[b]), .rdata(g_rdata[b]));
      pfb_bank_model #(.ADDR_W(4), .DEPTH(16)) u_rmem (
         .clk(clk), .en(r_en[b]), .we(r_we[b]), .addr(r_addr[b]),
         .wdata(r_wdata[b]), .rdata(r_rdata[b]));
   end

   // ---------------- reference model state ----------------
   logic [15:0] ref_img [2][2][NPIX];
   logic [15:0] stage   [2][4];
   int          ref_cnt [2];
   bit          ref_rdb [2];

   int    n_chk  = 0;
   int    n_fail = 0;
   bit    done   = 1'b0;
   int    cyc    = 0;
   string ctx    = "";

   function automatic int lanes_of(int m);   return (m == 0) ? 4 : 2;            endfunction
   function automatic int pw_of(int m);      return (m == 0) ? 8 : 16;           endfunction
   function automatic logic [15:0] mask_of(int m); return (m == 0) ? 16'h00ff : 16'hffff; endfunction

   function automatic bit act_we(int m, int b);   return (m == 0) ? g_we[b] : r_we[b]; endfunction
   function automatic bit act_en(int m, int b);   return (m == 0) ? g_en[b] : r_en[b]; endfunction
   function automatic int act_addr(int m, int b); return (m == 0) ? int'(g_addr[b]) : int'(r_addr[b]); endfunction
   function automatic bit act_rdb(int m);         return (m == 0) ? g_rd_bank : r_rd_bank; endfunction
   function automatic bit act_valid(int m);       return (m == 0) ? g_rd_valid : r_rd_valid; endfunction
   function automatic logic [31:0] act_word(int m);  return (m == 0) ? g_rd_word : r_rd_word; endfunction
   function automatic logic [31:0] act_lanes(int m); return (m == 0) ? 32'(g_rd_lanes) : 32'(r_rd_lanes); endfunction
   function automatic logic [15:0] act_pix(int m);   return (m == 0) ? {8'h00, g_rd_pix} : r_rd_pix; endfunction

   function automatic logic [31:0] exp_word(int m, int bank, int x, int y);
      int L = lanes_of(m);
      int p = y * FW + x;
      int base = (p / L) * L;
      logic [31:0] w = '0;
      for (int k = 0; k < L; k++)
         w = w | (32'(ref_img[m][bank][base + k] & mask_of(m)) << (k * pw_of(m)));
      return w;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s%s: actual %h expected %h", tag, ctx, act, expv);
      end
   endtask

   function automatic logic [15:0] pixval(int seed, int i);
      return 16'((seed * 4099 + i * 613 + 17) & 16'hffff);
   endfunction

   // one clock: drive at negedge, check combinational bank ports, then results after the edge
   task automatic step(input bit v, input bit sof, input bit eof, input logic [15:0] pix,
                       input bit rq, input int x, input int y);
      bit old_rdb [2];
      in_valid = v; in_sof = sof; in_eof = eof; in_pix = pix;
      rd_req = rq; rd_x = 3'(x); rd_y = 2'(y);
      #1;
      for (int m = 0; m < 2; m++) begin
         int L   = lanes_of(m);
         int idx = sof ? 0 : ref_cnt[m];
         bit commit = v && (idx < NPIX) && ((idx % L) == L - 1);
         int wb  = ref_rdb[m] ? 0 : 1;
         for (int b = 0; b < 2; b++) begin
            bit e_we = commit && (b == wb);
            bit e_en = (b == wb) ? commit : rq;
            chk(act_we(m, b) == e_we, "R1 write strobe", 32'(act_we(m, b)), 32'(e_we));
            chk(act_en(m, b) == e_en, "R3 bank access", 32'(act_en(m, b)), 32'(e_en));
         end
         if (commit)
            chk(act_addr(m, wb) == idx / L, "R5 word address", act_addr(m, wb), idx / L);
         old_rdb[m] = ref_rdb[m];
      end
      @(posedge clk);
      @(negedge clk);
      for (int m = 0; m < 2; m++) begin
         int L = lanes_of(m);
         int wb = ref_rdb[m] ? 0 : 1;
         if (v) begin
            int idx = sof ? 0 : ref_cnt[m];
            if (idx < NPIX) begin
               stage[m][idx % L] = pix & mask_of(m);
               if ((idx % L) == L - 1)
                  for (int k = 0; k < L; k++) ref_img[m][wb][idx - L + 1 + k] = stage[m][k];
            end
            if (eof) begin
               ref_cnt[m] = 0;
               ref_rdb[m] = !ref_rdb[m];
            end else begin
               ref_cnt[m] = (idx < NPIX) ? idx + 1 : idx;
            end
         end
         chk(act_rdb(m) == ref_rdb[m], "R2 readable bank", 32'(act_rdb(m)), 32'(ref_rdb[m]));
         chk(act_valid(m) == rq, "R7 read valid", 32'(act_valid(m)), 32'(rq));
         if (rq) begin
            logic [31:0] ew = exp_word(m, int'(old_rdb[m]), x, y);
            logic [15:0] ep = ref_img[m][int'(old_rdb[m])][y * FW + x] & mask_of(m);
            chk(act_word(m) == ew, "R4 packed word", act_word(m), ew);
            chk(act_lanes(m) == ew, "R4 lane split", act_lanes(m), ew);
            chk(act_pix(m) == ep, "R7 addressed pixel", 32'(act_pix(m)), 32'(ep));
         end
      end
   endtask

   task automatic send_frame(input int seed, input int n, input bit gaps, input bit with_eof);
      for (int i = 0; i < n; i++) begin
         if (gaps && (i % 5) == 3)
            step(1'b0, 1'b0, 1'b0, 16'hbeef, 1'b1, (i + 1) % FW, (i * 2) % FH);
         step(1'b1, i == 0, with_eof && (i == n - 1), pixval(seed, i),
              ((i % 2) == 0) || (i == n - 1), (i * 3) % FW, i % FH);
      end
   endtask

   task automatic read_all();
      for (int y = 0; y < FH; y++)
         for (int x = 0; x < FW; x++)
            step(1'b0, 1'b0, 1'b0, 16'h0, 1'b1, x, y);
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int m = 0; m < 2; m++) begin
         ref_cnt[m] = 0;
         ref_rdb[m] = 1'b1;
         for (int k = 0; k < 4; k++) stage[m][k] = '0;
         for (int b = 0; b < 2; b++)
            for (int p = 0; p < NPIX; p++) ref_img[m][b][p] = '0;
      end
      rst_n = 1'b0; in_valid = 0; in_sof = 0; in_eof = 0; in_pix = '0;
      rd_req = 0; rd_x = '0; rd_y = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      ctx = " [reset]";
      chk(g_rd_bank == 1'b1 && r_rd_bank == 1'b1, "R2 reset bank", {g_rd_bank, r_rd_bank}, 2'b11);
      chk(!g_rd_valid && !r_rd_valid, "R7 reset valid", {g_rd_valid, r_rd_valid}, 0);
      chk(g_we == 2'b00 && r_we == 2'b00, "R1 reset write", {g_we, r_we}, 0);

      ctx = " [R5 first frame with gaps]";
      send_frame(1, NPIX, 1'b1, 1'b1);
      read_all();

      ctx = " [R8 read in swap cycle]";
      send_frame(2, NPIX, 1'b0, 1'b1);
      read_all();
      send_frame(3, NPIX, 1'b1, 1'b1);
      read_all();

      ctx = " [R6 start flag restarts]";
      send_frame(4, 6, 1'b0, 1'b0);
      send_frame(5, NPIX, 1'b0, 1'b1);
      read_all();

      ctx = " [R9 over-long frame]";
      send_frame(6, NPIX + 3, 1'b0, 1'b1);
      read_all();

      ctx = " [R10 idle with flags]";
      step(1'b0, 1'b1, 1'b1, 16'hdead, 1'b1, 2, 1);
      step(1'b0, 1'b0, 1'b1, 16'hface, 1'b0, 0, 0);
      step(1'b0, 1'b1, 1'b0, 16'h1234, 1'b1, 7, 2);
      send_frame(7, 10, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b1, 16'h5555, 1'b1, 5, 0);
      send_frame(8, NPIX, 1'b0, 1'b1);
      read_all();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule